// File: doc/BRIEF.md
# Serial Four-Level Resistance Sense Decoder with Tunable Upper Reference

This block turns the digitized resistance of a two-bit-per-cell resistive memory cell into its two-bit symbol. A larger code means a higher resistance. Four resistance bands map to four symbols: the lowest band is 11, then 10, then 01, and the highest band is 00. The block does not compare the code against all three band edges at once. A single comparator walks through the edges in a fixed order, one edge per clock. The order is the 11/10 edge, then the 10/01 edge, then the 01/00 edge. The number of edges the code reaches selects the symbol.

The 10/01 edge is a constant, set halfway between the nominal codes of the two middle states. The 01/00 edge is picked at run time from an evenly spaced ladder of candidates. A high edge tolerates upward drift of cells that have been stored for a long time. A low edge tolerates the downward slide of worn cells in the highest-resistance state.

A 16-entry policy table makes the choice. Its row is set by the storage-time tag of the block being read, and its column by how many times the block has been programmed. The table comes out of reset favouring lower edges as wear grows. It can be rewritten through a small write port.

Top module: `mlcTunedSense`

## Requirements
- R1: After reset, `validOut` is low and `symbolOut` is 11.
- R2: With edges E1 (11/10, default 100), E2 (10/01) and E3 (01/00) taken in increasing order, the symbol is 11 for a code below E1, 10 for E1 up to E2, 01 for E2 up to E3, and 00 for a code at or above E3.
- R3: A code exactly equal to an edge resolves to the higher-resistance side of that edge.
- R4: E2 is the midpoint of the nominal 10 and 01 codes (default 300). The policy table never changes it.
- R5: E3 equals `CAND_BASE + k*CAND_STEP`, where k is the candidate index read from the policy table. The defaults are 500 + 64k for k = 0..3.
- R6: The table address is `{tagIn[7:6], cycIn[11:10]}`: the top two bits of the storage-time tag form the high half, and the top two bits of the cycle count form the low half.
- R7: After reset, every table entry holds `3 - cycleQuarter`, whatever the time tag.
- R8: A write strobe stores `cfgData` at `cfgAddr`. A start sampled on the same edge as the write still uses the old entry. Starts on later edges use the new entry.
- R9: A start sampled on edge k raises `validOut` for exactly the one cycle after edge k+3. `symbolOut` changes only on that edge and holds until the next decision.
- R10: A start sampled while a decision is in progress is ignored. A start sampled in the cycle where `validOut` is high begins a new decision.
- R11: The code and the table entry are captured on the start edge. Later changes to `codeIn`, `tagIn` or `cycIn` do not affect that decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| codeIn | input | 10 | Digitized cell resistance code |
| startIn | input | 1 | Begin a decision |
| tagIn | input | 8 | Storage-time tag of the block being read |
| cycIn | input | 12 | Program-cycle count of the block |
| cfgWe | input | 1 | Policy table write strobe |
| cfgAddr | input | 4 | Policy table entry address |
| cfgData | input | 2 | Candidate index to store |
| symbolOut | output | 2 | Decoded symbol |
| validOut | output | 1 | One-cycle decision strobe |

## Verification
The hardest cases to reach from the ports are the ones where timing overlaps: a table write landing on the same edge as a start, a second start arriving while the comparator is mid-walk, and a new start issued in the very cycle the previous result appears. The stimulus places each of these on an exact edge by driving inputs on the falling clock. A behavioural model tracks an outstanding-decision counter and a copy of the table, and is compared with the outputs on every cycle. Codes sitting exactly on E1, E2 and each selected E3 check the rule for ties at every edge.

// File: rtl/mlcSensePkg.sv
package mlcSensePkg;
  typedef enum logic [1:0] {
    REF_SET_EDGE   = 2'd0,
    REF_MID_EDGE   = 2'd1,
    REF_TUNED_EDGE = 2'd2
  } refSel_e;

  typedef struct packed {
    logic    load;
    logic    cmpEn;
    refSel_e refSel;
    logic    finish;
  } senseStrobes_t;

  localparam logic [1:0] SYM_LOWEST_R = 2'b11;
endpackage

// File: rtl/senseSeqCtrl.sv
module senseSeqCtrl
  import mlcSensePkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          startIn,
  output senseStrobes_t strobes
);
  typedef enum logic [1:0] {ST_IDLE, ST_EDGE0, ST_EDGE1, ST_EDGE2} seqState_e;
  seqState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext      = state;
    strobes        = '0;
    strobes.refSel = REF_SET_EDGE;
    case (state)
      ST_IDLE: begin
        if (startIn) begin
          strobes.load = 1'b1;
          stateNext    = ST_EDGE0;
        end
      end
      ST_EDGE0: begin
        strobes.cmpEn  = 1'b1;
        strobes.refSel = REF_SET_EDGE;
        stateNext      = ST_EDGE1;
      end
      ST_EDGE1: begin
        strobes.cmpEn  = 1'b1;
        strobes.refSel = REF_MID_EDGE;
        stateNext      = ST_EDGE2;
      end
      default: begin
        strobes.cmpEn  = 1'b1;
        strobes.refSel = REF_TUNED_EDGE;
        strobes.finish = 1'b1;
        stateNext      = ST_IDLE;
      end
    endcase
  end
endmodule

// File: rtl/thresholdPolicy.sv
module thresholdPolicy #(
  parameter int TAG_W    = 8,
  parameter int CYC_W    = 12,
  parameter int NUM_CAND = 4,
  localparam int CIDX_W  = (NUM_CAND > 1) ? $clog2(NUM_CAND) : 1,
  localparam int QBITS   = 2,
  localparam int ENTRIES = 1 << (2 * QBITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [TAG_W-1:0]     tagIn,
  input  logic [CYC_W-1:0]     cycIn,
  input  logic                 cfgWe,
  input  logic [2*QBITS-1:0]   cfgAddr,
  input  logic [CIDX_W-1:0]    cfgData,
  output logic [CIDX_W-1:0]    candIdx
);
  localparam int LIM = NUM_CAND - 1;

  logic [CIDX_W-1:0] policyTbl [ENTRIES];
  logic [QBITS-1:0]  timeQ, cycQ;

  function automatic logic [CIDX_W-1:0] defaultEntry(input int idx);
    int cq;
    cq = idx % (1 << QBITS);
    if (cq > LIM) cq = LIM;
    return CIDX_W'(LIM - cq);
  endfunction

  function automatic logic [CIDX_W-1:0] satIdx(input logic [CIDX_W-1:0] v);
    if (int'(v) > LIM) return CIDX_W'(LIM);
    return v;
  endfunction

  assign timeQ   = tagIn[TAG_W-1 -: QBITS];
  assign cycQ    = cycIn[CYC_W-1 -: QBITS];
  assign candIdx = policyTbl[{timeQ, cycQ}];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) policyTbl[i] <= defaultEntry(i);
    end else if (cfgWe) begin
      policyTbl[cfgAddr] <= satIdx(cfgData);
    end
  end
endmodule

// File: rtl/senseDatapath.sv
module senseDatapath
  import mlcSensePkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int TH_SET    = 100,
  parameter int TH_MID    = 300,
  parameter int CAND_BASE = 500,
  parameter int CAND_STEP = 64,
  parameter int NUM_CAND  = 4,
  localparam int CIDX_W   = (NUM_CAND > 1) ? $clog2(NUM_CAND) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  senseStrobes_t       strobes,
  input  logic [CODE_W-1:0]   codeIn,
  input  logic [CIDX_W-1:0]   candIdxIn,
  output logic [1:0]          symbolOut,
  output logic                validOut
);
  logic [CODE_W-1:0] candRef [NUM_CAND];
  logic [CODE_W-1:0] codeReg, refVal;
  logic [CIDX_W-1:0] candReg;
  logic [1:0]        hitCount;
  logic              geHit;

  for (genvar g = 0; g < NUM_CAND; g++) begin : gCand
    assign candRef[g] = CODE_W'(CAND_BASE + g * CAND_STEP);
  end

  always_comb begin
    case (strobes.refSel)
      REF_SET_EDGE: refVal = CODE_W'(TH_SET);
      REF_MID_EDGE: refVal = CODE_W'(TH_MID);
      default:      refVal = candRef[candReg];
    endcase
  end

  assign geHit = (codeReg >= refVal);

  always_ff @(posedge clk) begin
    if (rst) begin
      codeReg   <= '0;
      candReg   <= '0;
      hitCount  <= '0;
      symbolOut <= SYM_LOWEST_R;
      validOut  <= 1'b0;
    end else begin
      validOut <= strobes.finish;
      if (strobes.load) begin
        codeReg  <= codeIn;
        candReg  <= candIdxIn;
        hitCount <= '0;
      end else if (strobes.cmpEn) begin
        hitCount <= hitCount + {1'b0, geHit};
      end
      if (strobes.finish) symbolOut <= SYM_LOWEST_R - (hitCount + {1'b0, geHit});
    end
  end
endmodule

// File: rtl/mlcTunedSense.sv
module mlcTunedSense
  import mlcSensePkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int TAG_W     = 8,
  parameter int CYC_W     = 12,
  parameter int TH_SET    = 100,
  parameter int NOM_10    = 200,
  parameter int NOM_01    = 400,
  parameter int CAND_BASE = 500,
  parameter int CAND_STEP = 64,
  parameter int NUM_CAND  = 4,
  localparam int TH_MID   = (NOM_10 + NOM_01) / 2,
  localparam int CIDX_W   = (NUM_CAND > 1) ? $clog2(NUM_CAND) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              startIn,
  input  logic [TAG_W-1:0]  tagIn,
  input  logic [CYC_W-1:0]  cycIn,
  input  logic              cfgWe,
  input  logic [3:0]        cfgAddr,
  input  logic [CIDX_W-1:0] cfgData,
  output logic [1:0]        symbolOut,
  output logic              validOut
);
  senseStrobes_t     strobes;
  logic [CIDX_W-1:0] candIdx;

  senseSeqCtrl u_ctrl (
    .clk(clk), .rst(rst), .startIn(startIn), .strobes(strobes)
  );

  thresholdPolicy #(.TAG_W(TAG_W), .CYC_W(CYC_W), .NUM_CAND(NUM_CAND)) u_policy (
    .clk(clk), .rst(rst), .tagIn(tagIn), .cycIn(cycIn),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData), .candIdx(candIdx)
  );

  senseDatapath #(
    .CODE_W(CODE_W), .TH_SET(TH_SET), .TH_MID(TH_MID),
    .CAND_BASE(CAND_BASE), .CAND_STEP(CAND_STEP), .NUM_CAND(NUM_CAND)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .codeIn(codeIn),
    .candIdxIn(candIdx), .symbolOut(symbolOut), .validOut(validOut)
  );
endmodule

// File: rtl/mlcTunedSenseChk.sv
module mlcTunedSenseChk #(
  parameter int CODE_W    = 10,
  parameter int TH_SET    = 100,
  parameter int NOM_10    = 200,
  parameter int NOM_01    = 400,
  parameter int CAND_BASE = 500,
  parameter int CAND_STEP = 64,
  parameter int NUM_CAND  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] codeIn,
  input logic              startIn,
  input logic [1:0]        symbolOut,
  input logic              validOut
);
  localparam logic [CODE_W-1:0] E1  = CODE_W'(TH_SET);
  localparam logic [CODE_W-1:0] E2  = CODE_W'((NOM_10 + NOM_01) / 2);
  localparam logic [CODE_W-1:0] TOP = CODE_W'(CAND_BASE + (NUM_CAND - 1) * CAND_STEP);

  logic [1:0]        phase;
  logic [CODE_W-1:0] capCode;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      capCode <= '0;
    end else if (phase == 2'd0) begin
      if (startIn) begin
        phase   <= 2'd1;
        capCode <= codeIn;
      end
    end else begin
      phase <= phase + 2'd1;
    end
  end

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    validOut |=> !validOut);
  assert_valid_timing_R9: assert property (@(posedge clk) disable iff (rst)
    validOut |-> (phase == 2'd0 && $past(phase) == 2'd3));
  assert_symbol_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !validOut |-> $stable(symbolOut));
  assert_low_band_R2: assert property (@(posedge clk) disable iff (rst)
    (validOut && capCode < E1) |-> symbolOut == 2'b11);
  assert_mid_band_R4: assert property (@(posedge clk) disable iff (rst)
    (validOut && capCode >= E1 && capCode < E2) |-> symbolOut == 2'b10);
  assert_top_band_R5: assert property (@(posedge clk) disable iff (rst)
    (validOut && capCode >= TOP) |-> symbolOut == 2'b00);
endmodule

bind mlcTunedSense mlcTunedSenseChk #(
  .CODE_W(CODE_W), .TH_SET(TH_SET), .NOM_10(NOM_10), .NOM_01(NOM_01),
  .CAND_BASE(CAND_BASE), .CAND_STEP(CAND_STEP), .NUM_CAND(NUM_CAND)
) u_chk (
  .clk(clk), .rst(rst), .codeIn(codeIn), .startIn(startIn),
  .symbolOut(symbolOut), .validOut(validOut)
);

// File: tb/mlcTunedSense_tb.sv
module mlcTunedSense_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] codeIn = '0;
  logic       startIn = 1'b0;
  logic [7:0] tagIn = '0;
  logic [11:0] cycIn = '0;
  logic       cfgWe = 1'b0;
  logic [3:0] cfgAddr = '0;
  logic [1:0] cfgData = '0;
  logic [1:0] symbolOut;
  logic       validOut;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit modelLive = 0;
  bit finished = 0;
  string curReq = "R1";

  // behavioural model state
  int polTab [16];
  int busyCnt = 0;
  int capCode = 0;
  int capCand = 0;
  int expValid = 0;
  int expSym = 3;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mlcTunedSense u_dut (
    .clk(clk), .rst(rst), .codeIn(codeIn), .startIn(startIn), .tagIn(tagIn),
    .cycIn(cycIn), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .symbolOut(symbolOut), .validOut(validOut)
  );

  function automatic int decodeRef(input int code, input int cand);
    int n;
    n = 0;
    if (code >= 100) n++;
    if (code >= 300) n++;
    if (code >= 500 + 64 * cand) n++;
    return 3 - n;
  endfunction

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      for (int i = 0; i < 16; i++) polTab[i] = 3 - (i % 4);
      busyCnt = 0; expValid = 0; expSym = 3;
    end else begin
      expValid = 0;
      if (busyCnt > 0) begin
        busyCnt--;
        if (busyCnt == 0) begin
          expValid = 1;
          expSym = decodeRef(capCode, capCand);
        end
      end else if (startIn) begin
        capCode = int'(codeIn);
        capCand = polTab[{tagIn[7:6], cycIn[11:10]}];
        busyCnt = 3;
      end
      if (cfgWe) polTab[cfgAddr] = int'(cfgData);
    end
  end

  always @(negedge clk) begin
    if (modelLive) begin
      check(int'(validOut), expValid, {curReq, "/R9 model valid"});
      check(int'(symbolOut), expSym, {curReq, "/R9 model symbol"});
    end
  end

  task automatic decodeOnce(input int code, input int tag, input int cyc,
                            input int exp, input string req);
    curReq = req;
    @(negedge clk);
    codeIn = 10'(code); tagIn = 8'(tag); cycIn = 12'(cyc); startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    repeat (3) @(negedge clk);
    check(int'(validOut), 1, {req, " valid"});
    check(int'(symbolOut), exp, {req, " symbol"});
  endtask

  task automatic writeTbl(input int addr, input int data);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 4'(addr); cfgData = 2'(data);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(int'(validOut), 0, "R1 valid after reset");
    check(int'(symbolOut), 3, "R1 symbol after reset");
    modelLive = 1;

    // R2/R3 bands with default entry (idx 3, E3=692), R7
    decodeOnce(0,    0, 0, 3, "R2");
    decodeOnce(99,   0, 0, 3, "R2");
    decodeOnce(100,  0, 0, 2, "R3");
    decodeOnce(299,  0, 0, 2, "R4");
    decodeOnce(300,  0, 0, 1, "R3");
    decodeOnce(691,  0, 0, 1, "R7");
    decodeOnce(692,  0, 0, 0, "R3");
    decodeOnce(1023, 0, 0, 0, "R2");
    // R6/R7 cycle quarter picks lower edge; time tag ignored by default
    decodeOnce(499,  0, 12'hC00, 1, "R6");
    decodeOnce(500,  0, 12'hC00, 0, "R5");
    decodeOnce(627,  8'hC0, 12'h400, 1, "R7");
    decodeOnce(628,  8'hC0, 12'h400, 0, "R7");
    decodeOnce(563,  8'h40, 12'h800, 1, "R6");
    // R4 mid edge unaffected by selected E3
    decodeOnce(299,  0, 12'hC00, 2, "R4");
    decodeOnce(300,  0, 12'hC00, 1, "R4");

    // R8 table write
    writeTbl({2'd2, 2'd3}, 3);
    decodeOnce(600, 8'h80, 12'hC00, 1, "R8");
    decodeOnce(600, 8'h00, 12'hC00, 0, "R6");

    // R8 same-edge write and start uses old entry
    curReq = "R8";
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 4'd0; cfgData = 2'd0;
    codeIn = 10'd600; tagIn = '0; cycIn = '0; startIn = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0; startIn = 1'b0;
    repeat (3) @(negedge clk);
    check(int'(validOut), 1, "R8 same-edge valid");
    check(int'(symbolOut), 1, "R8 same-edge old entry");
    decodeOnce(600, 0, 0, 0, "R8");

    // R10 start while busy ignored
    curReq = "R10";
    @(negedge clk);
    codeIn = 10'd50; startIn = 1'b1;
    @(negedge clk);
    codeIn = 10'd900;
    @(negedge clk);
    @(negedge clk);
    startIn = 1'b0;
    @(negedge clk);
    check(int'(validOut), 1, "R10 first decision valid");
    check(int'(symbolOut), 3, "R10 busy start ignored");
    @(negedge clk);
    check(int'(validOut), 0, "R10 no second pulse");

    // R10 start in valid cycle accepted
    @(negedge clk);
    codeIn = 10'd50; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    repeat (3) @(negedge clk);
    check(int'(symbolOut), 3, "R10 first of pair");
    codeIn = 10'd900; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    check(int'(validOut), 0, "R9 pulse one cycle");
    repeat (3) @(negedge clk);
    check(int'(validOut), 1, "R10 back-to-back valid");
    check(int'(symbolOut), 0, "R10 back-to-back symbol");

    // R11 capture at start
    curReq = "R11";
    @(negedge clk);
    codeIn = 10'd600; tagIn = 8'h40; cycIn = 12'h000; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0; codeIn = 10'd1000; cycIn = 12'hC00;
    repeat (3) @(negedge clk);
    check(int'(validOut), 1, "R11 valid");
    check(int'(symbolOut), 1, "R11 captured code and entry");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule